// File: doc/BRIEF.md
# Eight-Function Integer ALU with Set-Less-Than

This block is a purely combinational arithmetic/logic unit of configurable width (32 bits by default). Two operands and a three-bit function code go in. One result word comes out, together with an optional all-zero indication and an optional adder carry. A single adder serves both addition and subtraction. The most significant code bit selects the complement of the second operand and also drives the adder's carry-in, so the adder forms `a + ~b + 1` when that bit is set. The two low code bits steer a four-way output selector. It picks the bitwise AND, the bitwise OR, the adder sum, or the sign bit of the sum zero-extended to full width.

The sign-bit selection yields a set-less-than result. It reports the raw top bit of `a - b` and makes no correction for signed overflow. The code `011`, which would otherwise return the zero-extended sign of an addition, is treated as unused and returns zero. A parameter selects the adder structure: either a log-depth parallel-prefix network or a plain behavioural carry chain.

Top module: `alu_core`

## Requirements
- R1: Code 000 gives `y = a & b`; code 001 gives `y = a | b`.
- R2: Code 010 gives `y = (a + b) mod 2^WIDTH`.
- R3: Code 011 is unused and gives `y = 0` for any operands.
- R4: Code 100 gives `y = a & ~b`; code 101 gives `y = a | ~b`.
- R5: Code 110 gives `y = (a - b) mod 2^WIDTH`.
- R6: Code 111 gives a result whose bits WIDTH-1..1 are zero. Bit 0 equals bit WIDTH-1 of `(a - b) mod 2^WIDTH`, with no correction for signed overflow. For example, a=25 and b=32 give y=1, while a=0x80000000 and b=1 give y=0.
- R7: With the zero flag enabled, `zero` is 1 exactly when `y` is all zeros, for every code including 011.
- R8: With the carry enabled, `cout` is the carry out of bit WIDTH-1 of the adder for every code. When code bit 2 is 0 that adder adds `a + b`. When code bit 2 is 1 it adds `a + ~b + 1`, so for 110 and 111 `cout` is 1 exactly when `a >= b` unsigned.
- R9: The outputs depend only on the present inputs and settle without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| fsel | input | 3 | Function code; bit 2 inverts b and sets carry-in, bits 1..0 pick the output |
| y_out | output | WIDTH | Result word |
| zero_out | output | 1 | Result is all zeros (tied 0 when HAS_ZERO=0) |
| cout_out | output | 1 | Adder carry out (tied 0 when HAS_COUT=0) |

## Verification
The embedded checks assume the operands and code are fully driven, known values whenever they are evaluated. They also assume the checks are read only after the combinational network has settled. They compare the prefix adder with a plain arithmetic sum and compare the result against an independent subtraction. The bench changes inputs only on the falling clock edge and samples on the rising edge, so every compared value has had half a period to settle. All eight codes are applied to directed corner operands: the signed-overflow compare, equal operands, and all-ones plus one. A stream of pseudo-random operand pairs is also applied under every code.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      PICK_AND  = 2'b00,
      PICK_OR   = 2'b01,
      PICK_SUM  = 2'b10,
      PICK_SIGN = 2'b11
   } pick_e;

   localparam logic [2:0] CODE_UNUSED = 3'b011;
   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_PREFIX = 1;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] b_raw,
   input  logic             invert,
   output logic [WIDTH-1:0] b_eff
);
   always_comb begin
      b_eff = invert ? ~b_raw : b_raw;
   end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 32,
   parameter int STYLE = 1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] z,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   import alu_pkg::*;

   localparam int COLS = WIDTH + 1;
   localparam int LG   = $clog2(COLS);

   if (STYLE != ADDER_RIPPLE && STYLE != ADDER_PREFIX) begin : g_bad_style
      $error("alu_adder: STYLE must be 0 or 1");
   end

   if (STYLE == ADDER_PREFIX) begin : g_prefix
      logic [LG:0][COLS-1:0] gg;
      logic [LG:0][COLS-1:0] pp;

      always_comb begin
         gg = '0;
         pp = '0;
         gg[0][0] = cin;
         pp[0][0] = 1'b0;
         for (int i = 0; i < WIDTH; i++) begin
            gg[0][i+1] = x[i] & z[i];
            pp[0][i+1] = x[i] ^ z[i];
         end
         for (int s = 0; s < LG; s++) begin
            for (int j = 0; j < COLS; j++) begin
               if (j >= (1 << s)) begin
                  gg[s+1][j] = gg[s][j] | (pp[s][j] & gg[s][j-(1<<s)]);
                  pp[s+1][j] = pp[s][j] & pp[s][j-(1<<s)];
               end else begin
                  gg[s+1][j] = gg[s][j];
                  pp[s+1][j] = pp[s][j];
               end
            end
         end
         for (int i = 0; i < WIDTH; i++) begin
            sum[i] = pp[0][i+1] ^ gg[LG][i];
         end
         cout = gg[LG][COLS-1];
      end

      // R2 / R5: prefix network agrees with a plain arithmetic sum
      always_comb begin
         a_r2_prefix_matches_sum: assert ({cout, sum} ==
            ({1'b0, x} + {1'b0, z} + {{WIDTH{1'b0}}, cin}));
      end
   end else begin : g_ripple
      always_comb begin
         {cout, sum} = {1'b0, x} + {1'b0, z} + {{WIDTH{1'b0}}, cin};
      end
   end
endmodule

// File: rtl/alu_outmux.sv
module alu_outmux #(
   parameter int WIDTH = 32
) (
   input  alu_pkg::pick_e   pick,
   input  logic             force_zero,
   input  logic [WIDTH-1:0] and_v,
   input  logic [WIDTH-1:0] or_v,
   input  logic [WIDTH-1:0] sum_v,
   output logic [WIDTH-1:0] y
);
   import alu_pkg::*;

   always_comb begin
      unique case (pick)
         PICK_AND:  y = and_v;
         PICK_OR:   y = or_v;
         PICK_SUM:  y = sum_v;
         PICK_SIGN: y = {{(WIDTH-1){1'b0}}, sum_v[WIDTH-1]};
         default:   y = '0;
      endcase
      if (force_zero) y = '0;
   end

   // R6: sign selection is zero-extended
   always_comb begin
      if (pick == PICK_SIGN && !force_zero)
         a_r6_sign_zero_extended: assert (y[WIDTH-1:1] == '0 && y[0] == sum_v[WIDTH-1]);
   end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 1,
   parameter int HAS_ZERO    = 1,
   parameter int HAS_COUT    = 1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [2:0]       fsel,
   output logic [WIDTH-1:0] y_out,
   output logic             zero_out,
   output logic             cout_out
);
   import alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_core: WIDTH must be at least 2");
   end
   if (HAS_ZERO != 0 && HAS_ZERO != 1) begin : g_bad_zero
      $error("alu_core: HAS_ZERO must be 0 or 1");
   end
   if (HAS_COUT != 0 && HAS_COUT != 1) begin : g_bad_cout
      $error("alu_core: HAS_COUT must be 0 or 1");
   end

   logic             invert_b;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum_v;
   logic             carry;
   logic [WIDTH-1:0] and_v;
   logic [WIDTH-1:0] or_v;
   pick_e            pick;
   logic             unused_code;

   always_comb begin
      invert_b    = fsel[2];
      pick        = pick_e'(fsel[1:0]);
      unused_code = (fsel == CODE_UNUSED);
   end

   alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .b_raw (b_in),
      .invert(invert_b),
      .b_eff (b_eff)
   );

   always_comb begin
      and_v = a_in & b_eff;
      or_v  = a_in | b_eff;
   end

   alu_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_add (
      .x   (a_in),
      .z   (b_eff),
      .cin (invert_b),
      .sum (sum_v),
      .cout(carry)
   );

   alu_outmux #(.WIDTH(WIDTH)) u_mux (
      .pick      (pick),
      .force_zero(unused_code),
      .and_v     (and_v),
      .or_v      (or_v),
      .sum_v     (sum_v),
      .y         (y_out)
   );

   if (HAS_ZERO == 1) begin : g_zero
      always_comb zero_out = ~|y_out;
   end else begin : g_no_zero
      always_comb zero_out = 1'b0;
   end

   if (HAS_COUT == 1) begin : g_cout
      always_comb cout_out = carry;
   end else begin : g_no_cout
      always_comb cout_out = 1'b0;
   end

   always_comb begin
      // R5: subtraction result equals an independent difference
      if (fsel == 3'b110)
         a_r5_sub_value: assert (y_out == a_in - b_in);
      // R3: the unused code never lets a value through
      if (fsel == CODE_UNUSED)
         a_r3_unused_zero: assert (y_out == '0);
      // R1: AND result has no bit outside a
      if (fsel == 3'b000)
         a_r1_and_subset: assert ((y_out & ~a_in) == '0);
      // R6: set-less-than follows the raw sign of the difference
      if (fsel == 3'b111)
         a_r6_slt_sign: assert (y_out == {{MSB{1'b0}}, (a_in - b_in) >> MSB});
      // R8: borrow-free subtraction gives carry when a >= b
      if (HAS_COUT == 1 && fsel[2:1] == 2'b11)
         a_r8_cout_compare: assert (cout_out == (a_in >= b_in));
   end
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
   localparam int W = 32;
   localparam int WATCHDOG_CYCLES = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [2:0]   fsel = 3'b000;
   logic [W-1:0] y_out;
   logic         zero_out;
   logic         cout_out;

   alu_core #(.WIDTH(W)) dut (
      .a_in(a_in), .b_in(b_in), .fsel(fsel),
      .y_out(y_out), .zero_out(zero_out), .cout_out(cout_out)
   );

   typedef struct {
      logic [W-1:0] y;
      logic         zero;
      logic         cout;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   function automatic string req_of(input logic [2:0] f);
      case (f)
         3'b000, 3'b001: return "R1";
         3'b010:         return "R2";
         3'b011:         return "R3";
         3'b100, 3'b101: return "R4";
         3'b110:         return "R5";
         default:        return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // driver: applies a vector on the falling edge and queues what the rising edge must show
   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
      exp_t e;
      logic [W:0] wide;
      logic [W-1:0] diff;
      @(negedge clk);
      a_in = a; b_in = b; fsel = f;
      diff = a - b;
      case (f)
         3'b000: e.y = a & b;
         3'b001: e.y = a | b;
         3'b010: e.y = a + b;
         3'b011: e.y = '0;
         3'b100: e.y = a & ~b;
         3'b101: e.y = a | ~b;
         3'b110: e.y = diff;
         default: e.y = {{(W-1){1'b0}}, diff[W-1]};
      endcase
      if (f[2]) e.cout = (a >= b);
      else begin
         wide = {1'b0, a} + {1'b0, b};
         e.cout = wide[W];
      end
      e.zero = (e.y == '0);
      e.tag  = req_of(f);
      exp_q.push_back(e);
   endtask

   // monitor: compares on the rising edge, half a period after the inputs moved (R9)
   always @(posedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.tag, y_out, e.y);
         check({e.tag, "/R7 zero"}, {{(W-1){1'b0}}, zero_out}, {{(W-1){1'b0}}, e.zero});
         check({e.tag, "/R8 cout"}, {{(W-1){1'b0}}, cout_out}, {{(W-1){1'b0}}, e.cout});
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // reset state: zero operands under code 000 (R1, R7)
      check("R1 reset y", y_out, '0);
      check("R7 reset zero", {{(W-1){1'b0}}, zero_out}, {{(W-1){1'b0}}, 1'b1});
      @(negedge clk);
      rst_n = 1'b1;

      drive(32'd25, 32'd32, 3'b111);               // R6: -7 is negative -> 1
      drive(32'd32, 32'd25, 3'b111);               // R6: positive difference -> 0
      drive(32'h8000_0000, 32'd1, 3'b111);         // R6: overflowed sign is not corrected -> 0
      drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111); // R6: raw sign of 0x80000000 -> 1
      drive(32'h1234_5678, 32'h1234_5678, 3'b110); // R5: equal operands, zero set, cout 1
      drive(32'hFFFF_FFFF, 32'd1, 3'b010);         // R2: wraps to zero with carry
      drive(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b011); // R3: unused code
      drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011); // R3: carry would be set, y still zero
      drive(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b100); // R4
      drive(32'h0000_0000, 32'hFFFF_FFFF, 3'b101); // R4: all-zero OR NOT
      drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b000); // R1: disjoint AND
      drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b001); // R1: complementary OR
      drive(32'd0, 32'd1, 3'b110);                 // R5: borrow, cout 0

      for (int k = 0; k < 200; k++) begin
         drive($urandom, $urandom, 3'(k % 8));
      end

      @(negedge clk);
      while (exp_q.size() > 0) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule